// File: doc/BRIEF.md
# BCD Timekeeper Register Window

This block puts a real-time clock behind eight byte registers at the top of a 13-bit parallel address space. The lowest address of the window holds a control byte. The seven addresses above it hold the seconds, minutes, hours, weekday, day of month, month and year, all in 24-hour BCD. The live clock counters are kept apart from these registers. They advance by one second for each pulse on the `tick` input. Software never reads the counters directly. It reads a visible buffer, and that buffer copies the counters every clock cycle while no hold is active.

A small state machine decides what the buffer does.

- **TRACK**: the buffer follows the counters.
- **FREEZE**: entered by setting the snapshot bit. The buffer holds a coherent copy while the counters keep running.
- **EDIT**: entered by setting the load bit. The buffer holds its contents and accepts new time values from software.

Every write to the control byte picks the next state. A set load bit selects EDIT. Otherwise a set snapshot bit selects FREEZE. Otherwise the next state is TRACK. When a control write leaves EDIT, all seven buffered fields are copied into the counters in a single cycle (the commit). A stop bit, a frequency-test flag and a century-enable flag can be written at any time and take effect at once.

Top module: `rtc_regwin`

## Requirements
- R1: The window is decoded from `addr[12:3] == 10'h3FF`. Offset 0 is control, 1 is seconds, 2 is minutes, 3 is hours, 4 is weekday, 5 is day of month, 6 is month and 7 is year. A read outside the window returns 8'h00, and a write outside the window changes nothing.
- R2: After reset, the control byte reads 8'h00 (state TRACK) and the stop, frequency-test and century-enable flags are 0. The counters read 00:00:00, weekday 1, day 01, month 01, year 00.
- R3: In TRACK, the visible registers show the counter value of the previous clock cycle. A tick is therefore visible two clock edges after the edge that samples it.
- R4: Control bit 6 is the snapshot bit. When it is written as 1 (with bit 7 at 0), the visible registers freeze at the values current when the bit was written, and the counters keep running. Writing it back to 0 makes the registers show the current time again by the second clock edge.
- R5: Control bit 7 is the load bit. When it is written as 1, refreshing stops, and writes to offsets 1 to 7 store BCD values in the visible registers. The control byte then reads with bit 7 set.
- R6: Writing the control byte with bit 7 at 0 while in EDIT copies all seven visible time fields into the counters at that clock edge. Counting continues from those values.
- R7: Bit 7 of the seconds register is the stop bit. It can be written at any time, with or without the load bit. While it is 1, ticks do not advance the counters.
- R8: Bit 6 of the weekday register (frequency test) and bit 5 (century enable) can be written at any time and read back at once.
- R9: While bit 7 of the control byte is 0, writes to offsets 1 to 7 leave the time fields unchanged. Only the flags of R7 and R8 are updated.
- R10: The counters roll over in BCD: seconds and minutes from 59 to 00, hours from 23 to 00, weekday from 7 to 1, month from 12 to 01, and year from 99 to 00.
- R11: The day of month rolls over to 01 after the last day of its month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by four and 28 days otherwise. All other months have 31 days.
- R12: Unused bits read as 0: control bits 5:0, minutes bit 7, hours bits 7:6, weekday bits 7 and 4:3, day bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 13 | Byte address |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |

## Verification
A wrong FSM state shows up directly on the control byte, on the very next read of offset 0. It also shows up as visible time registers that move while they should hold, or hold while they should move, within two clock edges of a tick.

A missed or partial commit can only be seen after the state returns to TRACK. It then appears as a wrong field two edges after the commit. A carry error in the counter chain stays hidden until the matching rollover tick. For that reason the bench places times just before each carry boundary and reads every field after a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_FREEZE = 2'd1,
        ST_EDIT   = 2'd2
    } win_state_e;

    localparam rtc_time_t RTC_EPOCH = '{yr: 8'h00, mon: 5'h01, date: 6'h01,
                                        dow: 3'd1, hr: 6'h00, min: 7'h00,
                                        sec: 7'h00};

    // Add one to a two-digit BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Last day of a month, as BCD; the year is BCD.
    function automatic logic [5:0] month_last(input logic [4:0] mon,
                                              input logic [7:0] yr);
        logic leap;
        logic [5:0] r;
        if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        case (mon)
            5'h02:                      r = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);

    rtc_time_t nxt;
    logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_yr;
    logic w_sec, w_min, w_hr, w_date, w_mon;

    always_comb begin
        nxt    = now;
        t_sec  = bcd_inc({1'b0, now.sec});
        t_min  = bcd_inc({1'b0, now.min});
        t_hr   = bcd_inc({2'b0, now.hr});
        t_date = bcd_inc({2'b0, now.date});
        t_mon  = bcd_inc({3'b0, now.mon});
        t_yr   = bcd_inc(now.yr);
        w_sec  = now.sec >= 7'h59;
        w_min  = now.min >= 7'h59;
        w_hr   = now.hr >= 6'h23;
        w_date = now.date >= month_last(now.mon, now.yr);
        w_mon  = now.mon >= 5'h12;
        nxt.sec = w_sec ? 7'h00 : t_sec[6:0];
        if (w_sec) begin
            nxt.min = w_min ? 7'h00 : t_min[6:0];
            if (w_min) begin
                nxt.hr = w_hr ? 6'h00 : t_hr[5:0];
                if (w_hr) begin
                    nxt.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
                    nxt.date = w_date ? 6'h01 : t_date[5:0];
                    if (w_date) begin
                        nxt.mon = w_mon ? 5'h01 : t_mon[4:0];
                        if (w_mon) nxt.yr = (now.yr >= 8'h99) ? 8'h00 : t_yr;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       now <= RTC_EPOCH;
        else if (load)    now <= load_val;
        else if (advance) now <= nxt;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> now == $past(load_val)); // R6
    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(now)); // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && now.sec == 7'h59) |=> now.sec == 7'h00); // R10

endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
    import rtc_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter logic [12:0] WIN_BASE = 13'h1FF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    localparam int OFF_W = 3;

    win_state_e st_q, st_d;
    rtc_time_t  vis, live;
    logic snap_q, stop_q, ftest_q, cent_q;
    logic hit, ctl_wr, commit, follow, edit_en;
    logic [OFF_W-1:0] off;

    assign hit    = addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W];
    assign off    = addr[OFF_W-1:0];
    assign ctl_wr = wr_en && hit && (off == 3'd0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_TRACK;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d    = st_q;
        commit  = 1'b0;
        follow  = 1'b0;
        edit_en = 1'b0;
        unique case (st_q)
            ST_TRACK:  follow  = 1'b1;
            ST_FREEZE: follow  = 1'b0;
            ST_EDIT:   edit_en = 1'b1;
            default:   follow  = 1'b0;
        endcase
        if (ctl_wr) begin
            if (wr_data[7])      st_d = ST_EDIT;
            else if (wr_data[6]) st_d = ST_FREEZE;
            else                 st_d = ST_TRACK;
            commit = edit_en && !wr_data[7];
        end
    end

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (tick && !stop_q),
        .load     (commit),
        .load_val (vis),
        .now      (live)
    );

    // Visible buffer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis     <= RTC_EPOCH;
            snap_q  <= 1'b0;
            stop_q  <= 1'b0;
            ftest_q <= 1'b0;
            cent_q  <= 1'b0;
        end else begin
            if (follow) vis <= live;
            if (ctl_wr) snap_q <= wr_data[6];
            if (wr_en && hit) begin
                unique case (off)
                    3'd1: begin
                        stop_q <= wr_data[7];
                        if (edit_en) vis.sec <= wr_data[6:0];
                    end
                    3'd2: if (edit_en) vis.min  <= wr_data[6:0];
                    3'd3: if (edit_en) vis.hr   <= wr_data[5:0];
                    3'd4: begin
                        ftest_q <= wr_data[6];
                        cent_q  <= wr_data[5];
                        if (edit_en) vis.dow <= wr_data[2:0];
                    end
                    3'd5: if (edit_en) vis.date <= wr_data[5:0];
                    3'd6: if (edit_en) vis.mon  <= wr_data[4:0];
                    3'd7: if (edit_en) vis.yr   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        rd_data = 8'h00;
        if (hit) begin
            unique case (off)
                3'd0: rd_data = {st_q == ST_EDIT, snap_q, 6'b0};
                3'd1: rd_data = {stop_q, vis.sec};
                3'd2: rd_data = {1'b0, vis.min};
                3'd3: rd_data = {2'b0, vis.hr};
                3'd4: rd_data = {1'b0, ftest_q, cent_q, 2'b0, vis.dow};
                3'd5: rd_data = {2'b0, vis.date};
                3'd6: rd_data = {3'b0, vis.mon};
                3'd7: rd_data = vis.yr;
                default: rd_data = 8'h00;
            endcase
        end
    end

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREEZE) |=> $stable(vis)); // R4
    AST_COMMIT_EXITS_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q != ST_EDIT) && (live == $past(vis))); // R6
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> rd_data == 8'h00); // R1

endmodule

// File: tb/tb_rtc_regwin.sv
module tb_rtc_regwin;

    localparam int CLK_PERIOD = 10;
    localparam logic [12:0] BASE = 13'h1FF8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [12:0] addr = '0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regwin dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: addr %h got %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] y);
        wr(BASE, 8'h80);
        wr(BASE + 13'd1, s); wr(BASE + 13'd2, m); wr(BASE + 13'd3, h);
        wr(BASE + 13'd4, dw); wr(BASE + 13'd5, dt); wr(BASE + 13'd6, mo);
        wr(BASE + 13'd7, y);
        wr(BASE, 8'h00);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(BASE, 8'h00, "R2");
        rd_chk(BASE + 13'd1, 8'h00, "R2");
        rd_chk(BASE + 13'd3, 8'h00, "R2");
        rd_chk(BASE + 13'd4, 8'h01, "R2");
        rd_chk(BASE + 13'd5, 8'h01, "R2");
        rd_chk(BASE + 13'd6, 8'h01, "R2");
        rd_chk(BASE + 13'd7, 8'h00, "R2");
    endtask

    task automatic t_window();
        rd_chk(13'h0000, 8'h00, "R1");
        wr(13'h0FF9, 8'h80);
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h01, "R1 R3");
    endtask

    task automatic t_edit_commit();
        wr(BASE, 8'h80);
        rd_chk(BASE, 8'h80, "R5");
        wr(BASE + 13'd1, 8'h30); wr(BASE + 13'd2, 8'h20); wr(BASE + 13'd3, 8'h10);
        wr(BASE + 13'd4, 8'h03); wr(BASE + 13'd5, 8'h15); wr(BASE + 13'd6, 8'h06);
        wr(BASE + 13'd7, 8'h24);
        rd_chk(BASE + 13'd1, 8'h30, "R5");
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h30, "R5");
        wr(BASE, 8'h00);
        repeat (2) @(negedge clk);
        rd_chk(BASE + 13'd1, 8'h30, "R6");
        rd_chk(BASE + 13'd2, 8'h20, "R6");
        rd_chk(BASE + 13'd3, 8'h10, "R6");
        rd_chk(BASE + 13'd4, 8'h03, "R6");
        rd_chk(BASE + 13'd5, 8'h15, "R6");
        rd_chk(BASE + 13'd6, 8'h06, "R6");
        rd_chk(BASE + 13'd7, 8'h24, "R6");
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h31, "R6 R3");
    endtask

    task automatic t_freeze();
        wr(BASE, 8'h40);
        rd_chk(BASE, 8'h40, "R4");
        pulse_tick();
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h31, "R4");
        wr(BASE, 8'h00);
        repeat (2) @(negedge clk);
        rd_chk(BASE + 13'd1, 8'h33, "R4");
    endtask

    task automatic t_stop();
        wr(BASE + 13'd1, 8'h80);
        repeat (2) @(negedge clk);
        rd_chk(BASE + 13'd1, 8'hB3, "R7");
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'hB3, "R7");
        wr(BASE + 13'd1, 8'h00);
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h34, "R7");
    endtask

    task automatic t_ignore();
        wr(BASE + 13'd2, 8'h55);
        repeat (2) @(negedge clk);
        rd_chk(BASE + 13'd2, 8'h20, "R9");
        wr(BASE + 13'd4, 8'h60);
        rd_chk(BASE + 13'd4, 8'h63, "R8 R9");
        wr(BASE + 13'd4, 8'h00);
        rd_chk(BASE + 13'd4, 8'h03, "R8");
        wr(BASE, 8'h3F);
        rd_chk(BASE, 8'h00, "R12");
    endtask

    task automatic t_rollover();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        pulse_tick();
        rd_chk(BASE + 13'd1, 8'h00, "R10");
        rd_chk(BASE + 13'd2, 8'h00, "R10");
        rd_chk(BASE + 13'd3, 8'h00, "R10");
        rd_chk(BASE + 13'd4, 8'h01, "R10");
        rd_chk(BASE + 13'd5, 8'h01, "R11");
        rd_chk(BASE + 13'd6, 8'h03, "R11");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        pulse_tick();
        rd_chk(BASE + 13'd5, 8'h29, "R11");
        rd_chk(BASE + 13'd6, 8'h02, "R11");
        rd_chk(BASE + 13'd4, 8'h04, "R10");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h29, 8'h02, 8'h24);
        pulse_tick();
        rd_chk(BASE + 13'd5, 8'h01, "R11");
        rd_chk(BASE + 13'd6, 8'h03, "R11");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
        pulse_tick();
        rd_chk(BASE + 13'd5, 8'h01, "R11");
        rd_chk(BASE + 13'd6, 8'h05, "R11");
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        pulse_tick();
        rd_chk(BASE + 13'd5, 8'h01, "R11");
        rd_chk(BASE + 13'd6, 8'h01, "R10");
        rd_chk(BASE + 13'd7, 8'h00, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_window();
        t_edit_commit();
        t_freeze();
        t_stop();
        t_ignore();
        t_rollover();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule